// File: doc/BRIEF.md
# Doorbell Handshake Mailbox

A device-side register block that lets a host pass a short request message to the device, and collect its reply, through one 32-bit doorbell register. The host writes a command word into the doorbell. If that command opens a handshake, the argument byte gives a dword count, and the next writes of that many dwords to the same address are captured as request data. Inside that window they are never decoded as commands.

Once the request is complete, the device side reads the captured dwords through a random-access port. It then loads 16-bit reply words one at a time and commits them. The commit raises a doorbell flag and starts the reply phase. In the reply phase, each doorbell read hands the host the next reply word in the low half of the data. Once all words have been read, one more read returns zero and the engine goes back to idle.

An interrupt status register and an interrupt mask register control a single interrupt output. A reset command at the doorbell discards any message that is waiting or being read out.

Top module: `db_mailbox`

## Requirements
- R1: Register offsets are 0x00 for the doorbell, 0x30 for interrupt status and 0x34 for interrupt mask. A read of any other offset, including 0x40 and 0x44, returns zero, and a write to any other offset has no effect.
- R2: A doorbell command word carries its function in bits 31:24 and its argument in bits 23:16. When idle, function 0x42 with a non-zero argument enters the collecting state. With argument zero it goes straight to the waiting state. Outside the reply phase, a doorbell read returns the state code in bits 1:0 (0 idle, 1 collecting, 2 waiting) and zero in all other bits.
- R3: After a handshake with argument N (1 to 255), the next N doorbell writes are stored at request indices 0 to N-1, whatever their function byte. After the Nth write, req_avail is 1, req_len is N, and req_rdata shows the dword at req_raddr.
- R4: In the waiting state, rpl_we appends rpl_wdata to the reply. A rpl_commit enters the reply phase and sets status bit 0 (the doorbell flag). A word pushed in the same cycle as the commit is included.
- R5: In the reply phase, each doorbell read returns {16'h0, word} in load order and advances to the next word.
- R6: A doorbell read after the last reply word returns zero, returns the engine to idle and sets status bit 3 (the reply flag).
- R7: The mask register holds bit 0 (masks the doorbell flag) and bit 3 (masks the reply flag). All other bits read as zero. irq is 1 exactly when a set flag has its mask bit clear.
- R8: A write to the status register clears each flag whose bit in the written data is 0 and keeps each flag whose bit is 1, so writing zero clears both. A flag set in the same cycle wins over the clear.
- R9: Function 0x40 written to the doorbell in any state other than collecting returns the engine to idle and discards the pending reply. It leaves the flags and the mask unchanged.
- R10: A doorbell write with any other function code, or a handshake written while not idle, leaves the state unchanged.
- R11: Reply words beyond RPL_DEPTH are dropped. rpl_we and rpl_commit have no effect outside the waiting state.
- R12: A synchronous active-high rst puts the engine in idle, clears both flags, sets both mask bits (mask reads 0x09) and drives irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a doorbell read has its side effect at the clock edge |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the same cycle |
| irq | output | 1 | Interrupt request |
| req_avail | output | 1 | Request captured, waiting for a reply |
| req_len | output | 8 | Number of request dwords captured |
| req_raddr | input | 8 | Request buffer read index |
| req_rdata | output | 32 | Request dword at req_raddr |
| rpl_we | input | 1 | Append one reply word |
| rpl_wdata | input | 16 | Reply word |
| rpl_commit | input | 1 | Reply complete; start the reply phase |

## Verification
The bench sends request dwords whose top byte equals the reset or handshake code. A design that decoded commands during collection would abort or restart on them, and the state and captured data would be wrong. It checks that the read after the last reply word returns zero, lands in idle and sets the reply flag. It also checks that pushes outside the waiting state and pushes beyond the reply depth are dropped. A design that got these wrong would hand back stale or extra words. Further cases cover the 255-dword maximum, partial clears of the status register, and a reset command in the middle of the reply phase that must leave the flags alone.

// File: rtl/db_pkg.sv
package db_pkg;

    localparam int CMD_W = 8;
    localparam int REQ_DEPTH = 2 ** CMD_W;

    localparam logic [CMD_W-1:0] FN_RESET  = 8'h40;
    localparam logic [CMD_W-1:0] FN_HSHAKE = 8'h42;

    localparam int OFF_DB    = 'h00;
    localparam int OFF_ISTAT = 'h30;
    localparam int OFF_IMASK = 'h34;

    localparam int FLAG_DB  = 0;
    localparam int FLAG_RPL = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_WAIT    = 2'd2,
        ST_REPLY   = 2'd3
    } hs_state_e;

    typedef struct packed {
        logic [CMD_W-1:0] func;
        logic [CMD_W-1:0] arg;
    } db_cmd_t;

    function automatic db_cmd_t split_cmd(input logic [31:0] w);
        db_cmd_t c;
        c.func = w[31:24];
        c.arg  = w[23:16];
        return c;
    endfunction

    function automatic logic [31:0] flag_word(input logic db, input logic rpl);
        logic [31:0] w;
        w = '0;
        w[FLAG_DB]  = db;
        w[FLAG_RPL] = rpl;
        return w;
    endfunction

endpackage

// File: rtl/db_req_store.sv
module db_req_store
    import db_pkg::*;
#(
    parameter int DEPTH = REQ_DEPTH,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          we,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [AW-1:0] wptr,
    output logic [31:0]   rdata
);

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || start) begin
            wptr <= '0;
        end else if (we) begin
            wptr <= wptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wptr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/db_rpl_store.sv
module db_rpl_store #(
    parameter int DEPTH = 32,
    localparam int PW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        push,
    input  logic [15:0] wdata,
    input  logic        pop,
    output logic [15:0] head,
    output logic        drained
);

    logic [15:0]   mem [DEPTH];
    logic [PW-1:0] cnt;
    logic [PW-1:0] rptr;
    logic          room;

    assign room = (cnt < PW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            rptr <= '0;
        end else begin
            if (push && room) begin
                cnt <= cnt + 1'b1;
            end
            if (pop && (rptr != cnt)) begin
                rptr <= rptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push && room) begin
            mem[cnt[IW-1:0]] <= wdata;
        end
    end

    assign drained = (rptr == cnt);
    assign head    = drained ? 16'h0 : mem[rptr[IW-1:0]];

endmodule

// File: rtl/db_irq_regs.sv
module db_irq_regs (
    input  logic clk,
    input  logic rst,
    input  logic set_db,
    input  logic set_rpl,
    input  logic stat_we,
    input  logic mask_we,
    input  logic wbit_db,
    input  logic wbit_rpl,
    output logic flag_db,
    output logic flag_rpl,
    output logic mask_db,
    output logic mask_rpl,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_db  <= 1'b0;
            flag_rpl <= 1'b0;
            mask_db  <= 1'b1;
            mask_rpl <= 1'b1;
        end else begin
            flag_db  <= set_db  | (flag_db  & ~(stat_we & ~wbit_db));
            flag_rpl <= set_rpl | (flag_rpl & ~(stat_we & ~wbit_rpl));
            if (mask_we) begin
                mask_db  <= wbit_db;
                mask_rpl <= wbit_rpl;
            end
        end
    end

    assign irq = (flag_db & ~mask_db) | (flag_rpl & ~mask_rpl);

endmodule

// File: rtl/db_fsm.sv
module db_fsm
    import db_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             db_wr,
    input  logic             db_rd,
    input  db_cmd_t          cmd,
    input  logic             rpl_commit,
    input  logic             rpl_drained,
    input  logic [CMD_W-1:0] coll_idx,
    output hs_state_e        state,
    output logic [CMD_W-1:0] req_len,
    output logic             coll_start,
    output logic             coll_we,
    output logic             rpl_clr,
    output logic             rpl_pop,
    output logic             rpl_accept,
    output logic             set_db,
    output logic             set_rpl
);

    hs_state_e nxt;
    logic      is_reset;

    assign is_reset = db_wr && (cmd.func == FN_RESET);

    always_comb begin
        nxt        = state;
        coll_start = 1'b0;
        coll_we    = 1'b0;
        rpl_clr    = 1'b0;
        rpl_pop    = 1'b0;
        rpl_accept = 1'b0;
        set_db     = 1'b0;
        set_rpl    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (db_wr && (cmd.func == FN_HSHAKE)) begin
                    coll_start = 1'b1;
                    rpl_clr    = 1'b1;
                    nxt        = (cmd.arg == '0) ? ST_WAIT : ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (db_wr) begin
                    coll_we = 1'b1;
                    if (coll_idx == req_len - 1'b1) begin
                        nxt = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (is_reset) begin
                    rpl_clr = 1'b1;
                    nxt     = ST_IDLE;
                end else begin
                    rpl_accept = 1'b1;
                    if (rpl_commit) begin
                        set_db = 1'b1;
                        nxt    = ST_REPLY;
                    end
                end
            end
            ST_REPLY: begin
                if (is_reset) begin
                    rpl_clr = 1'b1;
                    nxt     = ST_IDLE;
                end else if (db_rd) begin
                    if (rpl_drained) begin
                        set_rpl = 1'b1;
                        rpl_clr = 1'b1;
                        nxt     = ST_IDLE;
                    end else begin
                        rpl_pop = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req_len <= '0;
        end else begin
            state <= nxt;
            if (coll_start) begin
                req_len <= cmd.arg;
            end
        end
    end

endmodule

// File: rtl/db_mailbox.sv
module db_mailbox
    import db_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int RPL_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              req_avail,
    output logic [7:0]        req_len,
    input  logic [7:0]        req_raddr,
    output logic [31:0]       req_rdata,
    input  logic              rpl_we,
    input  logic [15:0]       rpl_wdata,
    input  logic              rpl_commit
);

    logic       sel_db, sel_stat, sel_mask;
    logic       db_wr, db_rd;
    db_cmd_t    db_cmd;
    hs_state_e  hs_state;
    logic [7:0] coll_idx;
    logic       coll_start, coll_we;
    logic       rpl_clr, rpl_pop, rpl_accept, rpl_drained;
    logic [15:0] rpl_head;
    logic       set_db, set_rpl;
    logic       flag_db, flag_rpl, mask_db, mask_rpl;

    assign sel_db   = (reg_addr == ADDR_W'(OFF_DB));
    assign sel_stat = (reg_addr == ADDR_W'(OFF_ISTAT));
    assign sel_mask = (reg_addr == ADDR_W'(OFF_IMASK));
    assign db_wr    = reg_wr && sel_db;
    assign db_rd    = reg_rd && sel_db;
    assign db_cmd   = split_cmd(reg_wdata);

    db_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .db_wr       (db_wr),
        .db_rd       (db_rd),
        .cmd         (db_cmd),
        .rpl_commit  (rpl_commit),
        .rpl_drained (rpl_drained),
        .coll_idx    (coll_idx),
        .state       (hs_state),
        .req_len     (req_len),
        .coll_start  (coll_start),
        .coll_we     (coll_we),
        .rpl_clr     (rpl_clr),
        .rpl_pop     (rpl_pop),
        .rpl_accept  (rpl_accept),
        .set_db      (set_db),
        .set_rpl     (set_rpl)
    );

    db_req_store #(.DEPTH(REQ_DEPTH)) u_req (
        .clk   (clk),
        .rst   (rst),
        .start (coll_start),
        .we    (coll_we),
        .wdata (reg_wdata),
        .raddr (req_raddr),
        .wptr  (coll_idx),
        .rdata (req_rdata)
    );

    db_rpl_store #(.DEPTH(RPL_DEPTH)) u_rpl (
        .clk     (clk),
        .rst     (rst),
        .clr     (rpl_clr),
        .push    (rpl_we && rpl_accept),
        .wdata   (rpl_wdata),
        .pop     (rpl_pop),
        .head    (rpl_head),
        .drained (rpl_drained)
    );

    db_irq_regs u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_db   (set_db),
        .set_rpl  (set_rpl),
        .stat_we  (reg_wr && sel_stat),
        .mask_we  (reg_wr && sel_mask),
        .wbit_db  (reg_wdata[FLAG_DB]),
        .wbit_rpl (reg_wdata[FLAG_RPL]),
        .flag_db  (flag_db),
        .flag_rpl (flag_rpl),
        .mask_db  (mask_db),
        .mask_rpl (mask_rpl),
        .irq      (irq)
    );

    assign req_avail = (hs_state == ST_WAIT);

    always_comb begin
        reg_rdata = '0;
        if (sel_db) begin
            if (hs_state == ST_REPLY) begin
                reg_rdata = {16'h0, rpl_head};
            end else begin
                reg_rdata = {30'h0, hs_state};
            end
        end else if (sel_stat) begin
            reg_rdata = flag_word(flag_db, flag_rpl);
        end else if (sel_mask) begin
            reg_rdata = flag_word(mask_db, mask_rpl);
        end
    end

endmodule

// File: rtl/db_mailbox_chk.sv
module db_mailbox_chk
    import db_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       db_wr,
    input logic       db_rd,
    input logic [7:0] func,
    input hs_state_e  state,
    input logic       rpl_commit,
    input logic       drained,
    input logic       flag_db,
    input logic       flag_rpl,
    input logic       mask_db,
    input logic       mask_rpl,
    input logic       irq
);

    AST_COMMIT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && rpl_commit && !(db_wr && func == FN_RESET))
        |=> (flag_db && state == ST_REPLY)); // R4

    AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REPLY && db_rd && drained && !(db_wr && func == FN_RESET))
        |=> (flag_rpl && state == ST_IDLE)); // R6

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_db && mask_rpl) |-> !irq); // R7

    AST_RESET_CMD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state != ST_COLLECT && db_wr && func == FN_RESET) |=> (state == ST_IDLE)); // R9

    AST_UNKNOWN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_COLLECT && db_wr && func != FN_RESET && func != FN_HSHAKE
         && !db_rd && !rpl_commit) |=> (state == $past(state))); // R10

endmodule

bind db_mailbox db_mailbox_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .db_wr      (db_wr),
    .db_rd      (db_rd),
    .func       (db_cmd.func),
    .state      (hs_state),
    .rpl_commit (rpl_commit),
    .drained    (rpl_drained),
    .flag_db    (flag_db),
    .flag_rpl   (flag_rpl),
    .mask_db    (mask_db),
    .mask_rpl   (mask_rpl),
    .irq        (irq)
);

// File: tb/sim_db_mailbox.sv
`timescale 1ns/1ps
module sim_db_mailbox;

    localparam int RPL_DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, req_avail;
    logic [7:0]  req_len;
    logic [7:0]  req_raddr = '0;
    logic [31:0] req_rdata;
    logic        rpl_we = 1'b0, rpl_commit = 1'b0;
    logic [15:0] rpl_wdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    db_mailbox #(.ADDR_W(8), .RPL_DEPTH(RPL_DEPTH)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .req_avail(req_avail), .req_len(req_len),
        .req_raddr(req_raddr), .req_rdata(req_rdata),
        .rpl_we(rpl_we), .rpl_wdata(rpl_wdata), .rpl_commit(rpl_commit)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h34, 32'h0,        32'h9, 4'd12}, // R12 mask reset
        '{1'b0, 8'h30, 32'h0,        32'h0, 4'd12}, // R12 flags reset
        '{1'b0, 8'h00, 32'h0,        32'h0, 4'd12}, // R12 idle
        '{1'b1, 8'h34, 32'hFFFFFFFF, 32'h0, 4'd7},
        '{1'b0, 8'h34, 32'h0,        32'h9, 4'd7},  // R7 only two bits
        '{1'b1, 8'h34, 32'h0,        32'h0, 4'd7},
        '{1'b0, 8'h34, 32'h0,        32'h0, 4'd7},
        '{1'b1, 8'h00, 32'h41000000, 32'h0, 4'd10},
        '{1'b0, 8'h00, 32'h0,        32'h0, 4'd10}, // R10 unknown ignored
        '{1'b1, 8'h40, 32'h12345678, 32'h0, 4'd1},
        '{1'b0, 8'h40, 32'h0,        32'h0, 4'd1},  // R1
        '{1'b0, 8'h44, 32'h0,        32'h0, 4'd1},
        '{1'b1, 8'h00, 32'h42030000, 32'h0, 4'd2},
        '{1'b0, 8'h00, 32'h0,        32'h1, 4'd2},  // R2 collecting
        '{1'b1, 8'h00, 32'h42000000, 32'h0, 4'd3},
        '{1'b1, 8'h00, 32'h40000000, 32'h0, 4'd3},
        '{1'b0, 8'h00, 32'h0,        32'h1, 4'd3},  // R3 still collecting
        '{1'b1, 8'h00, 32'hDEADBEEF, 32'h0, 4'd3},
        '{1'b0, 8'h00, 32'h0,        32'h2, 4'd3}   // R3 waiting
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        bus_rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic push(input logic [15:0] w, input logic commit);
        @(negedge clk);
        rpl_we = 1'b1; rpl_wdata = w; rpl_commit = commit;
        @(negedge clk);
        rpl_we = 1'b0; rpl_commit = 1'b0;
    endtask

    task automatic commit_only();
        @(negedge clk);
        rpl_commit = 1'b1;
        @(negedge clk);
        rpl_commit = 1'b0;
    endtask

    task automatic req_peek(input logic [7:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_raddr = idx;
        #1 check(tag, req_rdata, exp);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 check("R12 irq after reset", {31'h0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_wr(VECS[i].addr, VECS[i].data);
            end else begin
                rd_check(VECS[i].addr, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
            end
        end

        // R3 captured request contents
        check("R3 req_len", {24'h0, req_len}, 32'd3);
        check("R3 req_avail", {31'h0, req_avail}, 32'h1);
        req_peek(8'd0, 32'h42000000, "R3 dword 0");
        req_peek(8'd1, 32'h40000000, "R3 dword 1");
        req_peek(8'd2, 32'hDEADBEEF, "R3 dword 2");

        // R4 R5 R6 reply phase, mask cleared
        push(16'h1111, 1'b0);
        push(16'h2222, 1'b0);
        push(16'h3333, 1'b1);
        #1 check("R7 irq doorbell flag unmasked", {31'h0, irq}, 32'h1);
        rd_check(8'h30, 32'h1, "R4 doorbell flag");
        rd_check(8'h00, 32'h1111, "R5 reply word 0");
        push(16'h7777, 1'b1); // R11 ignored outside waiting
        rd_check(8'h00, 32'h2222, "R5 reply word 1");
        rd_check(8'h00, 32'h3333, "R5 reply word 2");
        rd_check(8'h00, 32'h0, "R6 read past end");
        rd_check(8'h00, 32'h0, "R6 idle after drain");
        rd_check(8'h30, 32'h9, "R6 reply flag set");

        // R8 partial and full clear
        bus_wr(8'h30, 32'h8);
        rd_check(8'h30, 32'h8, "R8 keep bit3 clear bit0");
        bus_wr(8'h30, 32'h0);
        rd_check(8'h30, 32'h0, "R8 zero clears");
        #1 check("R7 irq low with no flags", {31'h0, irq}, 32'h0);

        // R2 zero-length handshake, R10 handshake while waiting, R9 reset cmd
        bus_wr(8'h00, 32'h42000000);
        rd_check(8'h00, 32'h2, "R2 arg zero waits");
        bus_wr(8'h00, 32'h42050000);
        rd_check(8'h00, 32'h2, "R10 handshake ignored while waiting");
        bus_wr(8'h00, 32'h40000000);
        rd_check(8'h00, 32'h0, "R9 reset from waiting");

        // R9 reset in middle of reply, flags kept
        bus_wr(8'h00, 32'h42000000);
        push(16'h5555, 1'b0);
        push(16'h6666, 1'b1);
        rd_check(8'h00, 32'h5555, "R5 first word");
        bus_wr(8'h00, 32'h40000000);
        rd_check(8'h00, 32'h0, "R9 reset from reply");
        rd_check(8'h30, 32'h1, "R9 flags unchanged");
        bus_wr(8'h30, 32'h0);

        // R11 overflow of reply depth
        bus_wr(8'h00, 32'h42000000);
        for (int i = 0; i < RPL_DEPTH + 2; i++) push(16'h0100 + 16'(i), 1'b0);
        commit_only();
        for (int i = 0; i < RPL_DEPTH; i++)
            rd_check(8'h00, 32'h0100 + i, $sformatf("R11 word %0d", i));
        rd_check(8'h00, 32'h0, "R11 extra words dropped");
        bus_wr(8'h30, 32'h0);

        // R3 maximum length 255
        bus_wr(8'h00, 32'h42FF0000);
        for (int i = 0; i < 254; i++) bus_wr(8'h00, 32'hA0000000 + i);
        rd_check(8'h00, 32'h1, "R3 collecting at 254");
        bus_wr(8'h00, 32'hA00000FE);
        rd_check(8'h00, 32'h2, "R3 waiting after 255");
        check("R3 req_len 255", {24'h0, req_len}, 32'd255);
        req_peek(8'd0, 32'hA0000000, "R3 first of 255");
        req_peek(8'd254, 32'hA00000FE, "R3 last of 255");

        // R12 synchronous reset in reply phase
        commit_only();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_check(8'h00, 32'h0, "R12 idle after rst");
        rd_check(8'h30, 32'h0, "R12 flags after rst");
        rd_check(8'h34, 32'h9, "R12 mask after rst");
        #1 check("R12 irq after rst", {31'h0, irq}, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule